// File: doc/BRIEF.md
# Banked Processor Control Register File

This block holds a processor's control state behind one read/write port that is selected by a control register index. The state covers a status byte and its first backup, a condition flag, a second-level backup status, two backup program counters, two plain scratch words, and a pair of stack-pointer slots. Reads are combinational on the index. Writes take effect on the rising clock edge while the write enable is high.

The status byte's top bit selects the active stack. The live stack pointer, which is general register 15, sits in this block and is exposed on a side port. That port can be read and can be written through its own enable. The inactive stack pointer is kept in a banked slot. A status write that flips the stack-select bit swaps the live pointer and the banked copy in the same edge. Accesses to the interrupt or user stack index are routed either to the live pointer or to the banked slot, depending on which stack is active.

Top module: `ctrl_reg_bank`

## Requirements
- R1: After `rst_ni` is asserted, every control index reads zero and `sp_o` is zero.
- R2: Index 0 (status) reads as follows. Bits 15:8 hold the backup status byte ANDed with 0xC1. Bits 7:6 hold bits 7:6 of the status byte. Bit 0 holds the condition flag. All other bits read zero.
- R3: A write to index 0 makes three updates. Data bits 15:8 go to the backup status byte. Data bits 7:0 go to the status byte. Data bit 0 goes to the condition flag. Status bit 7 is the stack-select bit.
- R4: A write to index 0 that changes the stack-select bit swaps the stacks in that edge. On a change from 0 to 1, the live SP is saved to the interrupt slot and the live SP is loaded from the user slot. On a change from 1 to 0, the live SP is saved to the user slot and the live SP is loaded from the interrupt slot.
- R5: Index 2 (interrupt SP) accesses the live SP when stack-select is 0 and its slot otherwise. Index 3 (user SP) accesses the live SP when stack-select is 1 and its slot otherwise.
- R6: Index 1 reads the condition flag in bit 0, with zeros elsewhere. A write to index 1 sets the flag from data bit 0 only.
- R7: Indices 6 and 8 (backup PCs) read back the written word with bit 0 forced to 0.
- R8: Index 7 (second-level backup status) takes data bits 7:0 on a write and reads back that byte ANDed with 0xC1.
- R9: Indices 4 and 5 read back the full 32-bit word last written.
- R10: Any index above 8 reads zero. A write to such an index changes no other register and does not change `sp_o`.
- R11: When `sp_we_i` is high, `sp_wdata_i` is loaded into the live SP. This does not happen if, in the same cycle, a control write swaps the stacks or targets the live SP. In that case the control write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cr_idx_i | input | 4 | Control register index |
| cr_we_i | input | 1 | Control register write enable |
| cr_wdata_i | input | 32 | Control register write data |
| cr_rdata_o | output | 32 | Control register read data for `cr_idx_i` |
| sp_we_i | input | 1 | Live stack pointer write enable |
| sp_wdata_i | input | 32 | Live stack pointer write data |
| sp_o | output | 32 | Live stack pointer (general register 15) |

## Verification
The assertions take two things for granted. First, that `cr_idx_i`, `cr_we_i` and both write data buses are stable and known around each rising edge. Second, that the side-port write and the control write may arrive in the same cycle, with the control write expected to win. The stimulus drives every input on the falling edge and holds it for a full cycle. It deliberately pairs side-port writes with swapping status writes and with live-routed stack writes, so that the priority rules are exercised rather than avoided. It also crosses the stack-select bit in both directions, with different values in each slot, so that a swapped or missed copy shows up on `sp_o`.

// File: rtl/ctrl_reg_pkg.sv
`timescale 1ns/1ps
package ctrl_reg_pkg;
  localparam int XLEN  = 32;
  localparam int IDX_W = 4;

  localparam int CR_STAT   = 0;
  localparam int CR_COND   = 1;
  localparam int CR_ISP    = 2;
  localparam int CR_USP    = 3;
  localparam int CR_GP4    = 4;
  localparam int CR_GP5    = 5;
  localparam int CR_BPC    = 6;
  localparam int CR_BSTAT2 = 7;
  localparam int CR_BPC2   = 8;

  // plain register slots, in order of the plain-register bank
  localparam int NPLAIN    = 4;
  localparam logic [NPLAIN-1:0] PLAIN_CLR_LSB = 4'b1100;
endpackage

// File: rtl/ctrl_status.sv
`timescale 1ns/1ps
module ctrl_status (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        stat_we_i,
  input  logic        cond_we_i,
  input  logic        bstat2_we_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] stat_rd_o,
  output logic        cond_o,
  output logic [7:0]  bstat2_rd_o,
  output logic        sm_o
);
  // only the bits that can be read back are kept: 7, 6 and 0
  logic [1:0] stat_hi_q;
  logic [2:0] bstat_q;
  logic [2:0] bstat2_q;
  logic       cond_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_hi_q <= '0;
      bstat_q   <= '0;
      bstat2_q  <= '0;
      cond_q    <= 1'b0;
    end else begin
      if (stat_we_i) begin
        stat_hi_q <= wdata_i[7:6];
        bstat_q   <= {wdata_i[15:14], wdata_i[8]};
      end
      if (stat_we_i || cond_we_i) cond_q <= wdata_i[0];
      if (bstat2_we_i) bstat2_q <= {wdata_i[7:6], wdata_i[0]};
    end
  end

  assign stat_rd_o   = {bstat_q[2:1], 5'b0, bstat_q[0], stat_hi_q, 5'b0, cond_q};
  assign bstat2_rd_o = {bstat2_q[2:1], 5'b0, bstat2_q[0]};
  assign cond_o      = cond_q;
  assign sm_o        = stat_hi_q[1];

  // R3
  stat_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_we_i |=> (sm_o == $past(wdata_i[7])) && (cond_o == $past(wdata_i[0])));
  // R6
  cond_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_we_i |=> (stat_rd_o[0] == $past(wdata_i[0])) && $stable(sm_o));
endmodule

// File: rtl/ctrl_stack_bank.sv
`timescale 1ns/1ps
module ctrl_stack_bank #(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sm_i,
  input  logic            stat_we_i,
  input  logic            new_sm_i,
  input  logic            isp_we_i,
  input  logic            usp_we_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            sp_we_i,
  input  logic [XLEN-1:0] sp_wdata_i,
  output logic [XLEN-1:0] isp_rd_o,
  output logic [XLEN-1:0] usp_rd_o,
  output logic [XLEN-1:0] sp_o
);
  logic [XLEN-1:0] live_q, isp_q, usp_q;
  logic swap, cr_live_we;

  assign swap       = stat_we_i && (new_sm_i != sm_i);
  assign cr_live_we = (isp_we_i && !sm_i) || (usp_we_i && sm_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      isp_q  <= '0;
      usp_q  <= '0;
    end else if (swap) begin
      if (sm_i) begin
        usp_q  <= live_q;
        live_q <= isp_q;
      end else begin
        isp_q  <= live_q;
        live_q <= usp_q;
      end
    end else begin
      if (cr_live_we)   live_q <= wdata_i;
      else if (sp_we_i) live_q <= sp_wdata_i;
      if (isp_we_i && sm_i)  isp_q <= wdata_i;
      if (usp_we_i && !sm_i) usp_q <= wdata_i;
    end
  end

  assign isp_rd_o = sm_i ? isp_q : live_q;
  assign usp_rd_o = sm_i ? live_q : usp_q;
  assign sp_o     = live_q;

  // R4
  swap_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap && sm_i) |=> (sp_o == $past(isp_q)) && (usp_q == $past(sp_o)));
  // R4
  swap_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap && !sm_i) |=> (sp_o == $past(usp_q)) && (isp_q == $past(sp_o)));
  // R11
  sp_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sp_we_i && !swap && !cr_live_we) |=> sp_o == $past(sp_wdata_i));
  // R11
  cr_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sp_we_i && cr_live_we && !stat_we_i) |=> sp_o == $past(wdata_i));
endmodule

// File: rtl/ctrl_plain_regs.sv
`timescale 1ns/1ps
module ctrl_plain_regs #(
  parameter int                XLEN    = 32,
  parameter int                NREG    = 4,
  parameter logic [NREG-1:0]   CLR_LSB = '0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NREG-1:0]            we_i,
  input  logic [XLEN-1:0]            wdata_i,
  output logic [NREG-1:0][XLEN-1:0]  rd_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (CLR_LSB[i]) begin : g_even
      // bit 0 is never visible, so it is not stored
      logic [XLEN-1:1] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q <= '0;
        else if (we_i[i])  q <= wdata_i[XLEN-1:1];
      end
      assign rd_o[i] = {q, 1'b0};
    end else begin : g_full
      logic [XLEN-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q <= '0;
        else if (we_i[i])  q <= wdata_i;
      end
      assign rd_o[i] = q;
    end

    // R7 R9
    plain_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i[i] |=> rd_o[i][XLEN-1:1] == $past(wdata_i[XLEN-1:1]));
  end
endmodule

// File: rtl/ctrl_reg_bank.sv
`timescale 1ns/1ps
module ctrl_reg_bank
  import ctrl_reg_pkg::*;
#(
  parameter int DW = XLEN,
  parameter int IW = IDX_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] cr_idx_i,
  input  logic          cr_we_i,
  input  logic [DW-1:0] cr_wdata_i,
  output logic [DW-1:0] cr_rdata_o,
  input  logic          sp_we_i,
  input  logic [DW-1:0] sp_wdata_i,
  output logic [DW-1:0] sp_o
);
  function automatic logic sel(input logic [IW-1:0] idx, input int n);
    return idx == IW'(n);
  endfunction

  logic [15:0] stat_rd;
  logic [7:0]  bstat2_rd;
  logic        cond, sm;
  logic [DW-1:0] isp_rd, usp_rd;
  logic [NPLAIN-1:0] plain_we;
  logic [NPLAIN-1:0][DW-1:0] plain_rd;
  logic known;

  assign known = cr_idx_i <= IW'(CR_BPC2);

  ctrl_status u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stat_we_i   (cr_we_i && sel(cr_idx_i, CR_STAT)),
    .cond_we_i   (cr_we_i && sel(cr_idx_i, CR_COND)),
    .bstat2_we_i (cr_we_i && sel(cr_idx_i, CR_BSTAT2)),
    .wdata_i     (cr_wdata_i[15:0]),
    .stat_rd_o   (stat_rd),
    .cond_o      (cond),
    .bstat2_rd_o (bstat2_rd),
    .sm_o        (sm)
  );

  ctrl_stack_bank #(.XLEN(DW)) u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sm_i       (sm),
    .stat_we_i  (cr_we_i && sel(cr_idx_i, CR_STAT)),
    .new_sm_i   (cr_wdata_i[7]),
    .isp_we_i   (cr_we_i && sel(cr_idx_i, CR_ISP)),
    .usp_we_i   (cr_we_i && sel(cr_idx_i, CR_USP)),
    .wdata_i    (cr_wdata_i),
    .sp_we_i    (sp_we_i),
    .sp_wdata_i (sp_wdata_i),
    .isp_rd_o   (isp_rd),
    .usp_rd_o   (usp_rd),
    .sp_o       (sp_o)
  );

  assign plain_we = {cr_we_i && sel(cr_idx_i, CR_BPC2),
                     cr_we_i && sel(cr_idx_i, CR_BPC),
                     cr_we_i && sel(cr_idx_i, CR_GP5),
                     cr_we_i && sel(cr_idx_i, CR_GP4)};

  ctrl_plain_regs #(.XLEN(DW), .NREG(NPLAIN), .CLR_LSB(PLAIN_CLR_LSB)) u_plain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (plain_we),
    .wdata_i (cr_wdata_i),
    .rd_o    (plain_rd)
  );

  always_comb begin
    cr_rdata_o = '0;
    if (sel(cr_idx_i, CR_STAT))        cr_rdata_o = DW'(stat_rd);
    else if (sel(cr_idx_i, CR_COND))   cr_rdata_o = DW'(cond);
    else if (sel(cr_idx_i, CR_ISP))    cr_rdata_o = isp_rd;
    else if (sel(cr_idx_i, CR_USP))    cr_rdata_o = usp_rd;
    else if (sel(cr_idx_i, CR_GP4))    cr_rdata_o = plain_rd[0];
    else if (sel(cr_idx_i, CR_GP5))    cr_rdata_o = plain_rd[1];
    else if (sel(cr_idx_i, CR_BPC))    cr_rdata_o = plain_rd[2];
    else if (sel(cr_idx_i, CR_BSTAT2)) cr_rdata_o = DW'(bstat2_rd);
    else if (sel(cr_idx_i, CR_BPC2))   cr_rdata_o = plain_rd[3];
  end

  // R10
  unk_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cr_we_i && !known && !sp_we_i) |=> $stable(sp_o) && $stable(sm) && $stable(plain_rd));
endmodule

// File: tb/sim_ctrl_reg_bank.sv
`timescale 1ns/1ps
module sim_ctrl_reg_bank;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  cr_idx = '0;
  logic        cr_we = 1'b0;
  logic [31:0] cr_wdata = '0;
  logic [31:0] cr_rdata;
  logic        sp_we = 1'b0;
  logic [31:0] sp_wdata = '0;
  logic [31:0] sp;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // scoreboard queues
  logic [31:0] exp_q[$];
  bit          src_q[$];
  string       tag_q[$];

  // reference model
  logic [7:0]  m_stat, m_bstat, m_bstat2;
  logic        m_cond;
  logic [31:0] m_live, m_isp, m_usp, m_gp4, m_gp5, m_bpc, m_bpc2;

  always #5 clk = ~clk;

  ctrl_reg_bank u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cr_idx_i(cr_idx), .cr_we_i(cr_we),
    .cr_wdata_i(cr_wdata), .cr_rdata_o(cr_rdata), .sp_we_i(sp_we),
    .sp_wdata_i(sp_wdata), .sp_o(sp)
  );

  task automatic m_clear();
    m_stat = 0; m_bstat = 0; m_bstat2 = 0; m_cond = 0;
    m_live = 0; m_isp = 0; m_usp = 0; m_gp4 = 0; m_gp5 = 0; m_bpc = 0; m_bpc2 = 0;
  endtask

  function automatic logic [31:0] m_read(input logic [3:0] idx);
    case (idx)
      4'd0: return {16'b0, m_bstat & 8'hC1, m_stat[7:6], 5'b0, m_cond};
      4'd1: return {31'b0, m_cond};
      4'd2: return m_stat[7] ? m_isp : m_live;
      4'd3: return m_stat[7] ? m_live : m_usp;
      4'd4: return m_gp4;
      4'd5: return m_gp5;
      4'd6: return m_bpc & ~32'h1;
      4'd7: return {24'b0, m_bstat2 & 8'hC1};
      4'd8: return m_bpc2 & ~32'h1;
      default: return 32'h0;
    endcase
  endfunction

  // driver: one write cycle, model updated per requirements
  task automatic wr(input logic [3:0] idx, input logic [31:0] d,
                    input bit spwe = 0, input logic [31:0] spd = 0);
    bit blocked = 0;
    @(negedge clk);
    cr_idx = idx; cr_we = 1'b1; cr_wdata = d; sp_we = spwe; sp_wdata = spd;
    case (idx)
      4'd0: begin
        if (d[7] != m_stat[7]) begin
          blocked = 1;
          if (m_stat[7]) begin m_usp = m_live; m_live = m_isp; end
          else           begin m_isp = m_live; m_live = m_usp; end
        end
        m_bstat = d[15:8]; m_stat = d[7:0]; m_cond = d[0];
      end
      4'd1: m_cond = d[0];
      4'd2: if (m_stat[7]) m_isp = d; else begin m_live = d; blocked = 1; end
      4'd3: if (m_stat[7]) begin m_live = d; blocked = 1; end else m_usp = d;
      4'd4: m_gp4 = d;
      4'd5: m_gp5 = d;
      4'd6: m_bpc = d;
      4'd7: m_bstat2 = d[7:0];
      4'd8: m_bpc2 = d;
      default: ;
    endcase
    if (spwe && !blocked) m_live = spd;
    @(negedge clk);
    cr_we = 1'b0; sp_we = 1'b0;
  endtask

  task automatic sp_wr(input logic [31:0] d);
    @(negedge clk);
    cr_we = 1'b0; sp_we = 1'b1; sp_wdata = d; m_live = d;
    @(negedge clk);
    sp_we = 1'b0;
  endtask

  task automatic chk_rd(input logic [3:0] idx, input string tag);
    @(negedge clk);
    cr_idx = idx;
    exp_q.push_back(m_read(idx)); src_q.push_back(1'b0);
    tag_q.push_back($sformatf("%s idx%0d", tag, idx));
  endtask

  task automatic chk_sp(input string tag);
    @(negedge clk);
    exp_q.push_back(m_live); src_q.push_back(1'b1); tag_q.push_back({tag, " sp"});
  endtask

  task automatic chk_all(input string tag);
    for (int i = 0; i < 16; i++) chk_rd(4'(i), tag);
    chk_sp(tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (exp_q.size() > 0) begin
        logic [31:0] e, a;
        bit s;
        string t;
        e = exp_q.pop_front(); s = src_q.pop_front(); t = tag_q.pop_front();
        a = s ? sp : cr_rdata;
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", t, a, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1..: actual=hung expected=done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_clear();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    chk_all("R1 reset");

    wr(4'd0, 32'h0000_FF3E);                 chk_rd(0, "R2 R3 status");
    wr(4'd1, 32'hFFFF_FFFF);                 chk_rd(1, "R6 cond"); chk_rd(0, "R6 cond in status");
    wr(4'd1, 32'hFFFF_FFFE);                 chk_rd(1, "R6 cond clr");
    wr(4'd0, 32'h0000_3E41);                 chk_rd(0, "R2 status"); chk_rd(1, "R3 cond");
    sp_wr(32'h0000_1000);                    chk_sp("R11 port");
    wr(4'd2, 32'h0000_2000);                 chk_sp("R5 isp live"); chk_rd(2, "R5 isp");
    wr(4'd3, 32'h0000_3000);                 chk_rd(3, "R5 usp slot"); chk_sp("R5 usp slot");
    wr(4'd0, 32'h0000_0080);                 chk_sp("R4 up"); chk_rd(2, "R4 up"); chk_rd(3, "R4 up");
    sp_wr(32'h0000_3333);                    chk_rd(3, "R5 usp live");
    wr(4'd2, 32'h0000_2222);                 chk_sp("R5 isp slot"); chk_rd(2, "R5 isp slot");
    wr(4'd0, 32'h0000_0000);                 chk_sp("R4 down"); chk_rd(3, "R4 down"); chk_rd(2, "R4 down");
    wr(4'd0, 32'h0000_0040, 1, 32'h5555);    chk_sp("R11 no swap");
    wr(4'd0, 32'h0000_0080, 1, 32'h7777);    chk_sp("R11 swap prio"); chk_rd(2, "R11 swap prio");
    wr(4'd3, 32'h0000_4444, 1, 32'h9999);    chk_sp("R11 cr prio");
    wr(4'd2, 32'h0000_6666, 1, 32'hAAAA);    chk_sp("R11 slot write"); chk_rd(2, "R5 slot");
    wr(4'd6, 32'hDEAD_BEEF);                 chk_rd(6, "R7 bpc");
    wr(4'd8, 32'h1234_5679);                 chk_rd(8, "R7 bpc2");
    wr(4'd7, 32'hFFFF_FFFF);                 chk_rd(7, "R8 bstat2");
    wr(4'd7, 32'h0000_003E);                 chk_rd(7, "R8 bstat2 mask");
    wr(4'd4, 32'hFFFF_FFFF);                 chk_rd(4, "R9 gp4");
    wr(4'd5, 32'h0000_0001);                 chk_rd(5, "R9 gp5");
    wr(4'd9, 32'hFFFF_FFFF);
    wr(4'd15, 32'h0000_00FF);                chk_all("R10 unused idx");

    @(negedge clk);
    rst_ni = 1'b0;
    m_clear();
    @(negedge clk);
    rst_ni = 1'b1;
    chk_all("R1 re-reset");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule